// File: doc/BRIEF.md
# Tick-Sampled Serial IR Byte Receiver

This block recovers bytes from one active-low serial line, typically the output of an infrared receiver module after carrier removal. It does no timing of its own. A timer outside the block produces a one-cycle sample tick at a fixed rate, nominally one tick every 139 µs, and the receiver does all of its work on those ticks. The line first passes through a flop synchronizer. While the line is idle, the receiver checks it on every tick. A low sample starts a frame, and the level is checked again one tick later.

Once a start is confirmed, the frame is read at a spacing of three ticks: eight data bits with the least significant bit first, then a parity bit, then a stop bit. A frame is accepted only when its parity is odd and its stop bit is high. Otherwise it is dropped without any report and the receiver goes back to polling on every tick. An accepted byte goes into a holding register and sets a full flag, which the consumer clears once it has read the byte. If a new byte arrives while the flag is still set, the new byte replaces the old one and a one-cycle overrun pulse is raised.

Top module: `ir_byte_rx`

## Requirements
- R1: The line idles high. In the hunt state the synchronized line is checked on every tick, and a low sample begins a start check.
- R2: The start check takes exactly one more tick. If the line is high on that tick, the receiver returns to hunting and no byte is produced.
- R3: After a confirmed start, each later bit is sampled exactly three ticks after the previous sample. Levels present on the two ticks between samples have no effect.
- R4: The eight data bits arrive least significant first. The line level sampled for bit i becomes bit i of `data_o`.
- R5: The number of ones across the eight data bits and the parity bit must be odd. If it is even, the frame is dropped: `full_o` stays low and `data_o` keeps its previous value.
- R6: The stop bit, sampled three ticks after the parity bit, must be high. If it is low, the frame is dropped with the same effect as in R5.
- R7: After a dropped frame, the receiver hunts again on the very next tick, so a frame that follows at once is received.
- R8: An accepted frame loads `data_o` and sets `full_o`. The flag stays set until `clear_i` is sampled high, and it is low on the cycle after that. When a load and a clear fall on the same cycle, the load wins.
- R9: If a frame is accepted while `full_o` is set and `clear_i` is low, the new byte overwrites `data_o`, `full_o` stays set, and `overrun_o` is high for exactly one cycle.
- R10: Between ticks the frame state does not change, however the line moves.
- R11: After reset, `full_o` and `overrun_o` are low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle sample tick from an external prescaler |
| ir_line_i | input | 1 | Asynchronous serial line, active low, idles high |
| clear_i | input | 1 | Consumer clears the full flag |
| data_o | output | DATA_BITS (8) | Last accepted byte |
| full_o | output | 1 | A byte is waiting to be read |
| overrun_o | output | 1 | One-cycle pulse when an unread byte is overwritten |

## Verification
The assertions check the following on every cycle:
- The frame state moves only on ticks.
- The start check lasts a single tick.
- `data_o` changes only when a frame completes.
- The full flag holds until cleared and drops right after a clear.
- An overrun occurs only while the flag is already set.

The directed scenarios cover what needs whole frames to observe:
- bit order;
- the exact sampling tick, shown by surrounding each sampled tick with the opposite level;
- rejection of glitches, parity errors and stop errors;
- immediate recovery after a dropped frame;
- the overrun pulse.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT    = 3'd0,
        ST_CONFIRM = 3'd1,
        ST_DATA    = 3'd2,
        ST_PARITY  = 3'd3,
        ST_STOP    = 3'd4
    } rx_state_e;

endpackage

// File: rtl/ir_line_sync.sv
module ir_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = line_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], line_i};
        end
    endgenerate

    // Reset to ones: the line idles high, so no false start after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line_o = sync_q[STAGES-1];

endmodule

// File: rtl/ir_frame_fsm.sv
module ir_frame_fsm
    import ir_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int SPACING   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 line_i,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] byte_o,
    output rx_state_e            state_o
);

    localparam int CNT_W = (SPACING > 2) ? $clog2(SPACING) : 1;
    localparam int IDX_W = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(SPACING - 1);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e              state;
        logic [CNT_W-1:0]       cnt;
        logic [IDX_W-1:0]       idx;
        logic                   par;
        logic [DATA_BITS-1:0]   shreg;
        logic                   done;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        state: ST_HUNT,
        cnt:   '0,
        idx:   '0,
        par:   1'b0,
        shreg: '0,
        done:  1'b0
    };

    fsm_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (tick_i) begin
            unique case (r_q.state)
                ST_HUNT: begin
                    if (!line_i) r_d.state = ST_CONFIRM;
                end
                ST_CONFIRM: begin
                    if (line_i) begin
                        r_d.state = ST_HUNT;
                    end else begin
                        r_d.state = ST_DATA;
                        r_d.cnt   = CNT_RELOAD;
                        r_d.idx   = '0;
                        r_d.par   = 1'b0;
                    end
                end
                ST_DATA: begin
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end else begin
                        r_d.shreg = {line_i, r_q.shreg[DATA_BITS-1:1]};
                        r_d.par   = r_q.par ^ line_i;
                        r_d.cnt   = CNT_RELOAD;
                        if (r_q.idx == IDX_LAST) r_d.state = ST_PARITY;
                        else                     r_d.idx   = r_q.idx + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end else if (r_q.par ^ line_i) begin
                        r_d.state = ST_STOP;
                        r_d.cnt   = CNT_RELOAD;
                    end else begin
                        r_d.state = ST_HUNT;
                        r_d.cnt   = '0;
                        r_d.idx   = '0;
                        r_d.par   = 1'b0;
                    end
                end
                ST_STOP: begin
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end else begin
                        r_d.state = ST_HUNT;
                        r_d.cnt   = '0;
                        r_d.idx   = '0;
                        r_d.par   = 1'b0;
                        r_d.done  = line_i;
                    end
                end
                default: r_d = FSM_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= FSM_RST;
        else        r_q <= r_d;
    end

    assign done_o  = r_q.done;
    assign byte_o  = r_q.shreg;
    assign state_o = r_q.state;

endmodule

// File: rtl/ir_byte_hold.sv
module ir_byte_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             clear_i,
    output logic [WIDTH-1:0] data_o,
    output logic             full_o,
    output logic             overrun_o
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             full;
        logic             ovr;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d     = h_q;
        h_d.ovr = 1'b0;
        if (load_i) begin
            h_d.data = data_i;
            h_d.full = 1'b1;
            h_d.ovr  = h_q.full & ~clear_i;
        end else if (clear_i) begin
            h_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign data_o    = h_q.data;
    assign full_o    = h_q.full;
    assign overrun_o = h_q.ovr;

endmodule

// File: rtl/ir_byte_rx.sv
module ir_byte_rx
    import ir_rx_pkg::*;
#(
    parameter int DATA_BITS      = 8,
    parameter int SAMPLE_SPACING = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 ir_line_i,
    input  logic                 clear_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 full_o,
    output logic                 overrun_o
);

    logic                 line_s;
    logic                 frame_done;
    logic [DATA_BITS-1:0] frame_byte;
    rx_state_e            fsm_state;

    ir_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (ir_line_i),
        .line_o (line_s)
    );

    ir_frame_fsm #(.DATA_BITS(DATA_BITS), .SPACING(SAMPLE_SPACING)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .line_i  (line_s),
        .done_o  (frame_done),
        .byte_o  (frame_byte),
        .state_o (fsm_state)
    );

    ir_byte_hold #(.WIDTH(DATA_BITS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (frame_done),
        .data_i    (frame_byte),
        .clear_i   (clear_i),
        .data_o    (data_o),
        .full_o    (full_o),
        .overrun_o (overrun_o)
    );

endmodule

// File: rtl/ir_byte_rx_chk.sv
module ir_byte_rx_chk
    import ir_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_i,
    input logic                 clear_i,
    input logic                 done_i,
    input rx_state_e            state_i,
    input logic [DATA_BITS-1:0] data_i,
    input logic                 full_i,
    input logic                 overrun_i
);

    AST_STATE_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(state_i)); // R10

    AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> $past(tick_i)); // R10

    AST_CONFIRM_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_CONFIRM && tick_i) |=> state_i != ST_CONFIRM); // R2

    AST_DATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(data_i)); // R5

    AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> full_i); // R8

    AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_i && !clear_i) |=> full_i); // R8

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !done_i) |=> !full_i); // R8

    AST_OVERRUN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_i |-> (full_i && $past(full_i))); // R9

    AST_OVERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_i |=> !overrun_i); // R9

endmodule

bind ir_byte_rx ir_byte_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .clear_i   (clear_i),
    .done_i    (frame_done),
    .state_i   (fsm_state),
    .data_i    (data_o),
    .full_i    (full_o),
    .overrun_i (overrun_o)
);

// File: tb/ir_byte_rx_test.sv
module ir_byte_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       line = 1'b1;
    logic       clear = 1'b0;
    logic [7:0] data;
    logic       full;
    logic       overrun;

    int n_checks = 0;
    int n_fail   = 0;
    int ovr_seen = 0;

    always #10 clk = ~clk;

    ir_byte_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .ir_line_i (line),
        .clear_i   (clear),
        .data_o    (data),
        .full_o    (full),
        .overrun_o (overrun)
    );

    always @(negedge clk) if (overrun === 1'b1) ovr_seen++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One tick slot: drive the level, let it pass the synchronizer, then tick.
    task automatic slot(logic lvl);
        line = lvl;
        repeat (4) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) slot(1'b1);
    endtask

    // A bit spans three slots and is sampled in the middle one.
    // With mid_only set, the two outer slots carry the opposite level.
    task automatic bit3(logic b, logic mid_only);
        slot(mid_only ? ~b : b);
        slot(b);
        slot(mid_only ? ~b : b);
    endtask

    task automatic send(logic [7:0] b, logic par_good, logic stop_lvl, logic mid_only);
        logic p;
        p = par_good ? ~(^b) : (^b);
        slot(1'b0);
        slot(1'b0);
        slot(mid_only ? 1'b1 : 1'b0);
        for (int i = 0; i < 8; i++) bit3(b[i], mid_only);
        bit3(p, mid_only);
        bit3(stop_lvl, mid_only);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 full", full, 0);
        check("R11 overrun", overrun, 0);
        check("R11 data", data, 0);
    endtask

    task automatic t_basic();
        idle(3);
        send(8'h1E, 1'b1, 1'b1, 1'b0);
        idle(2);
        check("R4 LSB-first data", data, 8'h1E);
        check("R8 full set", full, 1);
        check("R1 start polled", ovr_seen, 0);
    endtask

    task automatic t_clear();
        idle(1);
        check("R8 held until clear", full, 1);
        do_clear();
        check("R8 cleared", full, 0);
    endtask

    task automatic t_sample_point();
        send(8'h5A, 1'b1, 1'b1, 1'b1);
        idle(2);
        check("R3 mid sample data", data, 8'h5A);
        check("R3 mid sample full", full, 1);
        do_clear();
    endtask

    task automatic t_glitch();
        idle(2);
        slot(1'b0);
        idle(40);
        check("R2 glitch rejected", full, 0);
        check("R2 data unchanged", data, 8'h5A);
    endtask

    task automatic t_bad_parity();
        send(8'h3C, 1'b0, 1'b1, 1'b0);
        idle(2);
        check("R5 parity full", full, 0);
        check("R5 parity data", data, 8'h5A);
    endtask

    task automatic t_bad_stop_recover();
        send(8'hC3, 1'b1, 1'b0, 1'b0);
        slot(1'b1);
        check("R6 stop full", full, 0);
        check("R6 stop data", data, 8'h5A);
        send(8'h81, 1'b1, 1'b1, 1'b0);
        idle(2);
        check("R7 recovered data", data, 8'h81);
        check("R7 recovered full", full, 1);
        do_clear();
    endtask

    task automatic t_overrun();
        ovr_seen = 0;
        send(8'h11, 1'b1, 1'b1, 1'b0);
        idle(2);
        check("R9 no overrun first", ovr_seen, 0);
        send(8'hE7, 1'b1, 1'b1, 1'b0);
        idle(2);
        check("R9 overrun pulses", ovr_seen, 1);
        check("R9 overwritten data", data, 8'hE7);
        check("R9 full kept", full, 1);
        do_clear();
    endtask

    task automatic t_no_tick();
        line = 1'b0;
        repeat (60) @(negedge clk);
        line = 1'b1;
        idle(40);
        check("R10 no tick no frame", full, 0);
        check("R10 data unchanged", data, 8'hE7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_clear();
        t_sample_point();
        t_glitch();
        t_bad_parity();
        t_bad_stop_recover();
        t_overrun();
        t_no_tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule